// File: doc/BRIEF.md
# Double-Buffered Crosspoint Route Controller

This block holds the routing of a crosspoint switch with `N_OUT` outputs and `N_IN` inputs. Each output has a 4-bit code that names the input feeding it. Software does not write the live routing directly. It fills one of two staging banks through a simple register write port. A strobe then copies a whole bank into the live (active) routing table at once, so every output changes in the same clock cycle.

The strobe comes from one of two sources. The first is a self-clearing software bit, which names the bank to copy. The second is an external select pin, which passes through a two-flop synchronizer. The pin works in one of two ways:

- **Level mode:** the active table follows staging bank A while the synchronized pin is low, and bank B while it is high.
- **Edge mode:** a rising edge of the pin loads bank B, and a falling edge loads bank A.

A key sequence written to a reset register returns both banks, the active table and the mode bits to their power-up values. At power-up every output routes from the input with its own number. The active codes drive a registered behavioural mux array. A code that names no input gives a constant low output.

Top module: `xpt_cfg_ctrl`

## Requirements
- R1: After `rst`, each output o has active code o, both staging banks hold code o for output o, and the block is in software strobe mode with bank A selected. So `dout[o]` equals `din[o]` one cycle after `din` is applied.
- R2: A write of `wr_data[3:0]` to address 8'h10+o sets the bank A entry for output o. A write to 8'h20+o sets the bank B entry. In software mode such a write leaves `act_sel` and `dout` unchanged until a strobe.
- R3: A write to address 8'h01 holds bit 7 (bank: 0 = A, 1 = B), bit 6 (pin mode: 0 = level, 1 = edge) and bit 0 (strobe). In software mode, a write with bit 0 set copies the chosen bank into `act_sel` on the second rising edge after the write is sampled.
- R4: The software strobe bit clears itself after one cycle. A single strobe write copies a bank once, and later bank writes do not reach `act_sel`.
- R5: Bit 0 of address 8'h00 selects the strobe source: 0 = software bit, 1 = select pin. In software mode the pin has no effect. In pin mode the software strobe bit has no effect.
- R6: In pin level mode, `act_sel` equals bank B while the synchronized pin is high and bank A while it is low. This includes bank writes made while the pin level holds.
- R7: In pin edge mode, a rising pin edge loads bank B and a falling edge loads bank A. Bank writes between edges do not change `act_sel`.
- R8: `dout[o]` is registered. It equals `din[c]` for the active code c of output o when c < `N_IN`, and 0 when c >= `N_IN` (for example 12 or 15).
- R9: Writing 8'hAA and then 8'h00 to address 8'hFF on two consecutive writes restores the R1 state. Any other write between the two breaks the sequence, and no reset takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| sel_pin | input | 1 | Asynchronous hardware select pin |
| din | input | N_IN | Crosspoint data inputs |
| act_sel | output | N_OUT*4 | Active select codes, output o at bits [4o+3:4o] |
| dout | output | N_OUT | Registered crosspoint data outputs |

## Verification
A corrupted staging bank stays hidden until a strobe or a pin event copies it. It then shows on `act_sel` within two edges of the strobe write, or three edges of a pin change, and on `dout` one edge later. A wrong strobe-source decision shows immediately as an `act_sel` change where none was due. The bench therefore compares the whole `act_sel` and `dout` vectors after every strobe, pin change and write that must have no effect. It also samples the cycle just before and just after a software copy, to pin down its latency.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam logic [ADDR_W-1:0] A_CFG   = 8'h00;
  localparam logic [ADDR_W-1:0] A_STB   = 8'h01;
  localparam logic [ADDR_W-1:0] A_BANKA = 8'h10;
  localparam logic [ADDR_W-1:0] A_BANKB = 8'h20;
  localparam logic [ADDR_W-1:0] A_RST   = 8'hFF;
  localparam logic [DATA_W-1:0] KEY_ARM = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_GO  = 8'h00;
  localparam int unsigned STB_BANK_BIT = 7;
  localparam int unsigned STB_EDGE_BIT = 6;
  localparam int unsigned STB_GO_BIT   = 0;
  localparam int unsigned CFG_SRC_BIT  = 0;
endpackage

// File: rtl/xpt_ctl_regs.sv
module xpt_ctl_regs
  import xpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              src_pin,
  output logic              pin_edge,
  output logic              sw_bank_b,
  output logic              sw_stb,
  output logic              mrst
);
  logic armed;

  // second key must follow the first with no other write between
  assign mrst = wr_en && armed && (wr_addr == A_RST) && (wr_data == KEY_GO);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (wr_en) begin
      armed <= (wr_addr == A_RST) && (wr_data == KEY_ARM);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || mrst) begin
      src_pin   <= 1'b0;
      pin_edge  <= 1'b0;
      sw_bank_b <= 1'b0;
      sw_stb    <= 1'b0;
    end else begin
      sw_stb <= 1'b0;
      if (wr_en && wr_addr == A_CFG) begin
        src_pin <= wr_data[CFG_SRC_BIT];
      end
      if (wr_en && wr_addr == A_STB) begin
        sw_bank_b <= wr_data[STB_BANK_BIT];
        pin_edge  <= wr_data[STB_EDGE_BIT];
        sw_stb    <= wr_data[STB_GO_BIT];
      end
    end
  end
endmodule

// File: rtl/xpt_stage_bank.sv
module xpt_stage_bank
  import xpt_pkg::*;
#(
  parameter int unsigned N_OUT = 12,
  parameter int unsigned SEL_W = 4,
  parameter logic [ADDR_W-1:0] BASE = 8'h10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [N_OUT*SEL_W-1:0] codes
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_ent
    localparam logic [SEL_W-1:0]  DEF = SEL_W'(o);
    localparam logic [ADDR_W-1:0] ADR = BASE + ADDR_W'(o);
    logic [SEL_W-1:0] ent;
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        ent <= DEF;
      end else if (wr_en && wr_addr == ADR) begin
        ent <= wr_data[SEL_W-1:0];
      end
    end
    assign codes[o*SEL_W +: SEL_W] = ent;
  end
endmodule

// File: rtl/xpt_strobe_ctl.sv
module xpt_strobe_ctl (
  input  logic clk,
  input  logic rst,
  input  logic sel_pin,
  input  logic src_pin,
  input  logic pin_edge,
  input  logic sw_stb,
  input  logic sw_bank_b,
  output logic ld_en,
  output logic ld_bank_b
);
  logic s1, s2, s2_d;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      s2_d <= 1'b0;
    end else begin
      s1   <= sel_pin;
      s2   <= s1;
      s2_d <= s2;
    end
  end

  assign rise = s2 & ~s2_d;
  assign fall = ~s2 & s2_d;

  always_comb begin
    if (!src_pin) begin
      ld_en     = sw_stb;
      ld_bank_b = sw_bank_b;
    end else if (!pin_edge) begin
      ld_en     = 1'b1;
      ld_bank_b = s2;
    end else begin
      ld_en     = rise | fall;
      ld_bank_b = rise;
    end
  end
endmodule

// File: rtl/xpt_active_tbl.sv
module xpt_active_tbl #(
  parameter int unsigned N_OUT = 12,
  parameter int unsigned SEL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   ld_en,
  input  logic                   ld_bank_b,
  input  logic [N_OUT*SEL_W-1:0] bank_a,
  input  logic [N_OUT*SEL_W-1:0] bank_b,
  output logic [N_OUT*SEL_W-1:0] act
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_act
    localparam logic [SEL_W-1:0] DEF = SEL_W'(o);
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        act[o*SEL_W +: SEL_W] <= DEF;
      end else if (ld_en) begin
        act[o*SEL_W +: SEL_W] <= ld_bank_b ? bank_b[o*SEL_W +: SEL_W]
                                           : bank_a[o*SEL_W +: SEL_W];
      end
    end
  end
endmodule

// File: rtl/xpt_mux_array.sv
module xpt_mux_array #(
  parameter int unsigned N_OUT = 12,
  parameter int unsigned N_IN  = 12,
  parameter int unsigned SEL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_IN-1:0]        din,
  input  logic [N_OUT*SEL_W-1:0] act,
  output logic [N_OUT-1:0]       dout
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_mux
    logic [SEL_W-1:0] code;
    logic             pick;
    assign code = act[o*SEL_W +: SEL_W];
    always_comb begin
      pick = 1'b0;
      for (int i = 0; i < N_IN; i++) begin
        if (code == SEL_W'(i)) pick = din[i];
      end
    end
    always_ff @(posedge clk) begin
      if (rst) dout[o] <= 1'b0;
      else     dout[o] <= pick;
    end
  end
endmodule

// File: rtl/xpt_cfg_ctrl.sv
module xpt_cfg_ctrl
  import xpt_pkg::*;
#(
  parameter int unsigned N_OUT = 12,
  parameter int unsigned N_IN  = 12,
  parameter int unsigned SEL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [7:0]             wr_addr,
  input  logic [7:0]             wr_data,
  input  logic                   sel_pin,
  input  logic [N_IN-1:0]        din,
  output logic [N_OUT*SEL_W-1:0] act_sel,
  output logic [N_OUT-1:0]       dout
);
  logic src_pin, pin_edge, sw_bank_b, sw_stb, mrst;
  logic ld_en, ld_bank_b;
  logic [N_OUT*SEL_W-1:0] bank_a_codes, bank_b_codes;

  xpt_ctl_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .src_pin(src_pin), .pin_edge(pin_edge), .sw_bank_b(sw_bank_b),
    .sw_stb(sw_stb), .mrst(mrst)
  );

  xpt_stage_bank #(.N_OUT(N_OUT), .SEL_W(SEL_W), .BASE(A_BANKA)) u_bank_a (
    .clk(clk), .rst(rst), .clr(mrst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .codes(bank_a_codes)
  );

  xpt_stage_bank #(.N_OUT(N_OUT), .SEL_W(SEL_W), .BASE(A_BANKB)) u_bank_b (
    .clk(clk), .rst(rst), .clr(mrst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .codes(bank_b_codes)
  );

  xpt_strobe_ctl u_stb (
    .clk(clk), .rst(rst), .sel_pin(sel_pin), .src_pin(src_pin),
    .pin_edge(pin_edge), .sw_stb(sw_stb), .sw_bank_b(sw_bank_b),
    .ld_en(ld_en), .ld_bank_b(ld_bank_b)
  );

  xpt_active_tbl #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_act (
    .clk(clk), .rst(rst), .clr(mrst), .ld_en(ld_en), .ld_bank_b(ld_bank_b),
    .bank_a(bank_a_codes), .bank_b(bank_b_codes), .act(act_sel)
  );

  xpt_mux_array #(.N_OUT(N_OUT), .N_IN(N_IN), .SEL_W(SEL_W)) u_mux (
    .clk(clk), .rst(rst), .din(din), .act(act_sel), .dout(dout)
  );
endmodule

// File: rtl/xpt_cfg_ctrl_chk.sv
module xpt_cfg_ctrl_chk
  import xpt_pkg::*;
#(
  parameter int unsigned N_OUT = 12,
  parameter int unsigned N_IN  = 12,
  parameter int unsigned SEL_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [7:0]             wr_addr,
  input logic [7:0]             wr_data,
  input logic                   sw_stb,
  input logic                   ld_en,
  input logic                   ld_bank_b,
  input logic                   mrst,
  input logic [N_OUT*SEL_W-1:0] bank_a_codes,
  input logic [N_OUT*SEL_W-1:0] bank_b_codes,
  input logic [N_OUT*SEL_W-1:0] act_sel,
  input logic [N_OUT-1:0]       dout
);
  logic [N_OUT*SEL_W-1:0] lane_def;
  always_comb begin
    for (int o = 0; o < N_OUT; o++) lane_def[o*SEL_W +: SEL_W] = SEL_W'(o);
  end

  // R2
  hold_without_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && !mrst) |=> $stable(act_sel));

  // R3
  load_copies_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_en && !mrst) |=> (act_sel == $past(ld_bank_b ? bank_b_codes : bank_a_codes)));

  // R4
  strobe_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_stb && !(wr_en && wr_addr == A_STB && wr_data[STB_GO_BIT])) |=> !sw_stb);

  // R9
  master_reset_chk: assert property (@(posedge clk) disable iff (rst)
    mrst |=> (act_sel == lane_def && bank_a_codes == lane_def && bank_b_codes == lane_def));

  for (genvar o = 0; o < N_OUT; o++) begin : g_chk
    // R8
    unrouted_low_chk: assert property (@(posedge clk) disable iff (rst)
      (act_sel[o*SEL_W +: SEL_W] >= SEL_W'(N_IN)) |=> !dout[o]);
  end
endmodule

bind xpt_cfg_ctrl xpt_cfg_ctrl_chk #(.N_OUT(N_OUT), .N_IN(N_IN), .SEL_W(SEL_W)) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .sw_stb(sw_stb), .ld_en(ld_en), .ld_bank_b(ld_bank_b), .mrst(mrst),
  .bank_a_codes(bank_a_codes), .bank_b_codes(bank_b_codes),
  .act_sel(act_sel), .dout(dout)
);

// File: tb/test_xpt_cfg_ctrl.sv
module test_xpt_cfg_ctrl;
  localparam int CLK_P = 10;
  localparam int N_OUT = 12;
  localparam int N_IN  = 12;
  localparam int SEL_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic sel_pin = 1'b0;
  logic [N_IN-1:0] din = '0;
  logic [N_OUT*SEL_W-1:0] act_sel;
  logic [N_OUT-1:0] dout;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [SEL_W-1:0] m_a [N_OUT];
  logic [SEL_W-1:0] m_b [N_OUT];
  logic [SEL_W-1:0] m_act [N_OUT];

  xpt_cfg_ctrl #(.N_OUT(N_OUT), .N_IN(N_IN), .SEL_W(SEL_W)) i_xpt_cfg_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel_pin(sel_pin), .din(din), .act_sel(act_sel), .dout(dout)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [N_OUT*SEL_W-1:0] exp_act();
    logic [N_OUT*SEL_W-1:0] v;
    for (int o = 0; o < N_OUT; o++) v[o*SEL_W +: SEL_W] = m_act[o];
    return v;
  endfunction

  function automatic logic [N_OUT-1:0] exp_dout();
    logic [N_OUT-1:0] v;
    for (int o = 0; o < N_OUT; o++) v[o] = (m_act[o] < SEL_W'(N_IN)) ? din[m_act[o]] : 1'b0;
    return v;
  endfunction

  task automatic model_defaults();
    for (int o = 0; o < N_OUT; o++) begin
      m_a[o] = SEL_W'(o); m_b[o] = SEL_W'(o); m_act[o] = SEL_W'(o);
    end
  endtask

  task automatic copy_bank(input bit use_b);
    for (int o = 0; o < N_OUT; o++) m_act[o] = use_b ? m_b[o] : m_a[o];
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a >= 8'h10 && a < 8'h10 + N_OUT) m_a[a - 8'h10] = d[SEL_W-1:0];
    if (a >= 8'h20 && a < 8'h20 + N_OUT) m_b[a - 8'h20] = d[SEL_W-1:0];
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req);
    checks++;
    if (act_sel !== exp_act() || dout !== exp_dout()) begin
      fails++;
      $display("FAIL %s: act_sel=%h dout=%h expected act_sel=%h dout=%h",
               req, act_sel, dout, exp_act(), exp_dout());
    end
  endtask

  task automatic check_act_only(input string req);
    checks++;
    if (act_sel !== exp_act()) begin
      fails++;
      $display("FAIL %s: act_sel=%h expected %h", req, act_sel, exp_act());
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_defaults();
    din = N_IN'($urandom);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);
    check("R1 reset lane routing");

    // R8: unrouted codes drive low
    wr(8'h10, 8'h0C); wr(8'h11, 8'h0F); wr(8'h01, 8'h01);
    copy_bank(0);
    idle(3);
    din = '1; idle(2);
    check("R8 code above range gives 0");

    // R2: staged writes stay hidden
    for (int o = 0; o < N_OUT; o++) wr(8'h10 + 8'(o), 8'($urandom_range(0, 11)));
    for (int o = 0; o < N_OUT; o++) wr(8'h20 + 8'(o), 8'($urandom_range(0, 11)));
    idle(4);
    check("R2 bank writes no effect before strobe");

    // R3: exact latency of a software copy of bank B
    wr(8'h01, 8'h81);
    check_act_only("R3 one edge after strobe write still old");
    copy_bank(1);
    @(negedge clk);
    check_act_only("R3 bank B copied on second edge");
    wr(8'h01, 8'h01);
    @(negedge clk);
    copy_bank(0);
    idle(2);
    check("R3 bank A copied");

    // R4: strobe fires once only
    wr(8'h10, 8'h03); wr(8'h15, 8'h07);
    idle(4);
    check("R4 strobe self-clears, later writes hidden");

    // R3 random mix
    for (int it = 0; it < 40; it++) begin
      int nw = $urandom_range(1, 5);
      for (int k = 0; k < nw; k++) begin
        logic [7:0] a = ($urandom_range(0, 1) ? 8'h20 : 8'h10) + 8'($urandom_range(0, N_OUT-1));
        wr(a, 8'($urandom_range(0, 15)));
      end
      din = N_IN'($urandom);
      if ($urandom_range(0, 2) != 0) begin
        bit bsel = 1'($urandom);
        wr(8'h01, {bsel, 6'b0, 1'b1});
        copy_bank(bsel);
      end
      idle(3);
      check("R3 random stage/strobe");
    end

    // R5: pin ignored in software mode
    sel_pin = 1'b1; idle(5); sel_pin = 1'b0; idle(5);
    check("R5 pin ignored in software mode");

    // R6: level mode
    wr(8'h01, 8'h00);
    wr(8'h00, 8'h01);
    copy_bank(0); idle(4);
    check("R6 level mode pin low follows bank A");
    sel_pin = 1'b1; copy_bank(1); idle(5);
    check("R6 level mode pin high follows bank B");
    wr(8'h22, 8'h09); copy_bank(1); idle(4);
    check("R6 level mode bank B write tracked");

    // R7: edge mode
    sel_pin = 1'b0; copy_bank(0); idle(5);
    wr(8'h01, 8'h40); idle(4);
    check("R7 edge mode entry keeps bank A");
    wr(8'h14, 8'h02); idle(4);
    check("R7 bank A write hidden between edges");
    sel_pin = 1'b1; copy_bank(1); idle(5);
    check("R7 rising edge loads bank B");
    wr(8'h23, 8'h0B); idle(4);
    check("R7 bank B write hidden while pin high");
    wr(8'h01, 8'h41); idle(4);
    check("R5 software strobe ignored in pin mode");
    sel_pin = 1'b0; copy_bank(0); idle(5);
    check("R7 falling edge loads bank A");

    // back to software mode
    wr(8'h00, 8'h00); idle(3);
    check("R5 source switch alone changes nothing");

    // R9: interrupted key sequence
    wr(8'hFF, 8'hAA); wr(8'h10, 8'h05); wr(8'hFF, 8'h00);
    idle(3);
    check("R9 broken sequence no reset");
    wr(8'h01, 8'h01); copy_bank(0); idle(3);
    check("R9 banks kept after broken sequence");

    // R9: proper sequence
    wr(8'hFF, 8'hAA); wr(8'hFF, 8'h00);
    model_defaults(); din = N_IN'($urandom); idle(3);
    check("R9 master reset restores lane routing");
    wr(8'h01, 8'h81); idle(3);
    check("R9 bank B back to defaults");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule